// File: doc/BRIEF.md
# DMA Page Register Bank

This block holds the upper address byte for every DMA channel of a system built around two four-channel DMA controllers, whose own counters only reach 16 bits. Software reaches the bank through a 32-byte I/O window starting at 0x80. Only 16 bytes of storage sit behind that window, so the upper half mirrors the lower half. The host bus is 32 bits wide, and each access is cut into byte accesses, one for each enabled lane.

The bytes are not laid out in channel order. Inside each 8-byte group, four bytes act as channel pages and the other four are plain scratch bytes. Window offset bit 3 chooses between the page set of the first controller and the page set of the second. The block watches the acknowledge lines of the first controller and records which channel was granted most recently. It then places that channel's page byte above the controller's 16-bit offset to form a 24-bit transfer address.

Top module: `dma_page_bank`

## Requirements
- R1: After reset all 16 storage bytes read as 0x00, the recorded channel is 0, and `xferAddr` equals `{8'h00, dmaOffset}`.
- R2: A write stores the bytes of its enabled lanes at the next clock edge. A read returns those bytes on `rdData` one clock after the read is presented.
- R3: Storage is indexed by window offset modulo 16, so byte addresses 0x80+n and 0x90+n name the same byte.
- R4: A 32-bit access to word address A (with A[1:0] ignored) reaches byte A+k through lane k, with lane k on data bits 8k+7:8k (little-endian).
- R5: A lane whose `byteEn` bit is 0 leaves its byte unchanged on a write and returns 0x00 on a read.
- R6: An access with `ioAddr[15:5]` other than 0x80>>5 changes no storage and returns 0 on `rdData`.
- R7: For the first controller the page of channel 0 is at window offset 7, channel 1 at offset 3, channel 2 at offset 1 and channel 3 at offset 2. `xferAddr` is `{page[recorded channel], dmaOffset}`.
- R8: The page bytes of the second controller (offsets 8 to 15) have no effect on `xferAddr`.
- R9: The recorded channel changes only at a clock edge where one of the `dackN` bits has gone from 1 to 0 since the edge before. If several bits fall at the same edge, the lowest-numbered channel wins. When `dackN` rises again, the recorded channel does not change.
- R10: Offsets 0, 4, 5 and 6 of each group are scratch bytes that read back the value last written to them.
- R11: A read of a channel page offset returns the same byte that `xferAddr` uses for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 16 | I/O byte address of the word accessed |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| byteEn | input | 4 | Byte lane enables |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after the read |
| dackN | input | 4 | Channel acknowledge lines of the first controller, active low |
| dmaOffset | input | 16 | Low 16 address bits from the controller |
| xferAddr | output | 24 | Full transfer address |

## Verification
A write changes storage at the clock edge where it is presented. Read data is registered and appears one edge after the read strobe. A falling acknowledge is recorded at the first edge that sees it low, and `xferAddr` follows combinationally from the recorded channel and `dmaOffset`, so the new address is visible just after that edge. The bench drives every input on the falling clock edge and samples at the next falling edge, so each result is read half a cycle after the single rising edge that produces it.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
  localparam int PAGE_W      = 8;
  localparam int LANES       = 4;
  localparam int STORE_BYTES = 16;
  localparam int WORD_SEL_W  = $clog2(STORE_BYTES / LANES);

  typedef struct packed {
    logic [STORE_BYTES-1:0] wrByte;   // one write strobe per storage byte
    logic [LANES-1:0]       rdLanes;  // lanes to return on this read
    logic [WORD_SEL_W-1:0]  rdWord;   // word within storage for the read
  } strobe_t;
endpackage

// File: rtl/dma_page_ctrl.sv
module dma_page_ctrl
  import dma_page_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 'h80,
  parameter int NUM_CH   = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int WIN_LSB = $clog2(2 * STORE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [LANES-1:0]  byteEn,
  input  logic [NUM_CH-1:0] dackN,
  output strobe_t           strobe,
  output logic [CH_W-1:0]   activeCh
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);

  logic                  winHit;
  logic [WORD_SEL_W-1:0] wordSel;
  logic [NUM_CH-1:0]     dackPrev;
  logic [NUM_CH-1:0]     fallVec;
  logic [CH_W-1:0]       nextCh;

  assign winHit  = (ioAddr[ADDR_W-1:WIN_LSB] == BASE_V[ADDR_W-1:WIN_LSB]);
  assign wordSel = ioAddr[WORD_SEL_W+1:2];

  for (genvar w = 0; w < STORE_BYTES / LANES; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign strobe.wrByte[w*LANES+l] =
        winHit && busWr && byteEn[l] && (wordSel == WORD_SEL_W'(w));
    end
  end

  assign strobe.rdLanes = (winHit && busRd) ? byteEn : '0;
  assign strobe.rdWord  = wordSel;

  assign fallVec = dackPrev & ~dackN;

  always_comb begin
    nextCh = activeCh;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (fallVec[c]) nextCh = CH_W'(c);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dackPrev <= '1;
      activeCh <= '0;
    end else begin
      dackPrev <= dackN;
      activeCh <= nextCh;
    end
  end

  // R9: without a falling acknowledge the recorded channel holds
  p_ch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fallVec == '0) |=> $stable(activeCh));

  // R9: channel 0 wins whenever its acknowledge falls
  p_ch0_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dackN[0]) |=> (activeCh == '0));
endmodule

// File: rtl/dma_page_data.sv
module dma_page_data
  import dma_page_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int OFF_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int IDX_W = $clog2(STORE_BYTES),
  localparam int BUS_W = LANES * PAGE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  input  logic [BUS_W-1:0]         wrData,
  input  logic [CH_W-1:0]          activeCh,
  input  logic [OFF_W-1:0]         dmaOffset,
  output logic [BUS_W-1:0]         rdData,
  output logic [PAGE_W+OFF_W-1:0]  xferAddr
);
  logic [STORE_BYTES-1:0][PAGE_W-1:0] store;
  logic [IDX_W-1:0]                   pageIdx;

  // Offset of each channel's page inside the first controller's group
  function automatic logic [IDX_W-1:0] chSlot(input logic [CH_W-1:0] ch);
    case (ch)
      2'd0:    chSlot = IDX_W'(7);
      2'd1:    chSlot = IDX_W'(3);
      2'd2:    chSlot = IDX_W'(1);
      default: chSlot = IDX_W'(2);
    endcase
  endfunction

  for (genvar b = 0; b < STORE_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 store[b] <= '0;
      else if (strobe.wrByte[b]) store[b] <= wrData[(b % LANES)*PAGE_W +: PAGE_W];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   rdData[l*PAGE_W +: PAGE_W] <= '0;
      else if (strobe.rdLanes[l])  rdData[l*PAGE_W +: PAGE_W] <= store[{strobe.rdWord, 2'(l)}];
      else                         rdData[l*PAGE_W +: PAGE_W] <= '0;
    end
  end

  assign pageIdx  = chSlot(activeCh);
  assign xferAddr = {store[pageIdx], dmaOffset};

  // R5: with no write strobe the storage holds
  p_store_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrByte == '0) |=> $stable(store));

  // R6: a cycle with no read lane yields zero read data
  p_rd_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLanes == '0) |=> (rdData == '0));
endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank
  import dma_page_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 'h80,
  parameter int NUM_CH   = 4,
  parameter int OFF_W    = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       ioAddr,
  input  logic                    busWr,
  input  logic                    busRd,
  input  logic [3:0]              byteEn,
  input  logic [31:0]             wrData,
  output logic [31:0]             rdData,
  input  logic [NUM_CH-1:0]       dackN,
  input  logic [OFF_W-1:0]        dmaOffset,
  output logic [PAGE_W+OFF_W-1:0] xferAddr
);
  localparam int CH_W = $clog2(NUM_CH);

  strobe_t         strobe;
  logic [CH_W-1:0] activeCh;

  dma_page_ctrl #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .busWr(busWr), .busRd(busRd),
    .byteEn(byteEn), .dackN(dackN), .strobe(strobe), .activeCh(activeCh)
  );

  dma_page_data #(.NUM_CH(NUM_CH), .OFF_W(OFF_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .activeCh(activeCh), .dmaOffset(dmaOffset), .rdData(rdData), .xferAddr(xferAddr)
  );

  // R7: the low address bits always come straight from the controller
  p_low_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    xferAddr[OFF_W-1:0] == dmaOffset);
endmodule

// File: tb/dma_page_bank_bench.sv
module dma_page_bank_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  dackN = 4'hF;
  logic [15:0] dmaOffset = 16'h1234;
  logic [23:0] xferAddr;

  int checks = 0, errors = 0;
  logic [7:0] model [16];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_bank u_dma_page_bank (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic inWin(input logic [15:0] a);
    return a[15:5] == 11'h004;
  endfunction

  task automatic busWrite(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    ioAddr = a; byteEn = be; wrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    if (inWin(a))
      for (int l = 0; l < 4; l++) if (be[l]) model[{a[3:2], 2'(l)}] = d[8*l +: 8];
  endtask

  task automatic busRead(input string tag, input logic [15:0] a, input logic [3:0] be);
    logic [31:0] exp;
    exp = '0;
    if (inWin(a))
      for (int l = 0; l < 4; l++) if (be[l]) exp[8*l +: 8] = model[{a[3:2], 2'(l)}];
    ioAddr = a; byteEn = be; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    check(tag, rdData, exp);
  endtask

  task automatic ackChannel(input string tag, input logic [3:0] lowMask, input logic [7:0] expPage);
    dackN = ~lowMask;
    @(negedge clk);
    check(tag, {8'h0, xferAddr}, {8'h0, expPage, dmaOffset});
    dackN = 4'hF;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int w = 0; w < 8; w++) busRead("R1 reset read", 16'h0080 + 16'(4*w), 4'hF);
    check("R1 reset address", {8'h0, xferAddr}, 32'h0000_1234);
  endtask

  task automatic t_lanes;
    busWrite(16'h0080, 4'hF, 32'h4433_2211);
    busRead("R2 R4 lane order", 16'h0080, 4'hF);
    check("R4 byte0 in lane0", rdData, 32'h4433_2211);
    busRead("R3 alias read", 16'h0090, 4'hF);
    busWrite(16'h0094, 4'b0101, 32'hAABB_CCDD);
    busRead("R3 R5 partial write", 16'h0084, 4'hF);
    check("R5 partial write value", rdData, 32'h00BB_00DD);
    busRead("R5 masked read", 16'h0084, 4'b0011);
  endtask

  task automatic t_window;
    busWrite(16'h00A0, 4'hF, 32'hFFFF_FFFF);
    busWrite(16'h007C, 4'hF, 32'hFFFF_FFFF);
    busWrite(16'h0180, 4'hF, 32'hFFFF_FFFF);
    busRead("R6 storage untouched", 16'h0080, 4'hF);
    busRead("R6 outside read zero", 16'h00A0, 4'hF);
  endtask

  task automatic t_pages;
    busWrite(16'h0080, 4'hF, 32'h3123_1200);  // ch2=12 ch3=23 ch1=31
    busWrite(16'h0084, 4'hF, 32'h7060_5040);  // ch0=70, scratch 40/50/60
    busWrite(16'h0088, 4'hF, 32'hEEEE_EEEE);  // second controller
    busWrite(16'h008C, 4'hF, 32'hEEEE_EEEE);
    busRead("R10 R11 scratch and ch0 page", 16'h0084, 4'hF);
    busRead("R11 page bytes", 16'h0080, 4'hF);
    dmaOffset = 16'hBEEF;
    ackChannel("R7 R8 R11 channel 0", 4'b0001, 8'h70);
    ackChannel("R7 R8 channel 1", 4'b0010, 8'h31);
    ackChannel("R7 R8 channel 2", 4'b0100, 8'h12);
    ackChannel("R7 R8 channel 3", 4'b1000, 8'h23);
  endtask

  task automatic t_latch;
    ackChannel("R9 latch ch1", 4'b0010, 8'h31);
    check("R9 hold after release", {8'h0, xferAddr}, {16'h0031, dmaOffset});
    ackChannel("R9 lowest wins", 4'b1100, 8'h12);
    dackN = 4'b0111;
    @(negedge clk);
    dmaOffset = 16'h0042;
    #1;
    check("R9 ch3 then low held", {8'h0, xferAddr}, 32'h0023_0042);
    @(negedge clk);
    check("R9 steady low holds", {8'h0, xferAddr}, 32'h0023_0042);
    dackN = 4'hF;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_window();
    t_pages();
    t_latch();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule